// File: doc/BRIEF.md
# Thread-Tagged Branch Target Buffer

This block predicts the target of a taken branch during instruction fetch. A fetch stage presents a program counter and the number of the hardware thread that issued it. One cycle later the block reports whether it holds a target for that address and that thread, and if so, which target. Once a branch resolves, the back end writes the branch address, the resolved target and the thread number into the buffer. A synchronous flush drops every stored prediction.

The buffer is direct-mapped. The low address bits just above the instruction-alignment bits pick one slot. The bits above the slot index, cut to a configured width, form the tag. Each slot keeps a valid flag, the tag, the target and the number of the thread that wrote it, so a slot written by one thread does not predict for another. The slot count, tag width, alignment shift, address width and thread-number width are all parameters. The slot count must be a power of two.

Top module: `tbtb_top`

## Requirements
- R1: After reset, and after any cycle with `flush_i` high, every slot is empty: later lookups miss until a slot is written again. Flush has priority over an update in the same cycle, so that update is lost.
- R2: Slot index = (PC >> SHIFT) mod SLOTS. Tag = (PC >> (SHIFT + log2(SLOTS))) mod 2^TAG_W.
- R3: `hit_o` is 1 only when the indexed slot is valid, its stored tag equals the lookup tag, and its stored thread number equals `look_tid_i`.
- R4: When `hit_o` is 0, `tgt_o` is all zeros. When `hit_o` is 1, `tgt_o` is the stored target.
- R5: The result of a lookup presented with `look_vld_i` high appears on `hit_o`/`tgt_o` at the next clock edge. A cycle with `look_vld_i` low produces `hit_o` = 0 in the following cycle.
- R6: An update unconditionally overwrites its slot with valid = 1 and the new tag, target and thread number. Two addresses that share an index evict each other.
- R7: If a lookup and an update address the same slot in the same cycle, the lookup sees the slot's old contents. The new contents are visible from the next cycle.
- R8: If SLOTS is not a power of two, elaboration fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all slots |
| look_vld_i | input | 1 | Lookup request strobe |
| look_pc_i | input | PC_W | Fetch address to look up |
| look_tid_i | input | TID_W | Thread number of the lookup |
| upd_vld_i | input | 1 | Update request strobe |
| upd_pc_i | input | PC_W | Resolved branch address |
| upd_tgt_i | input | PC_W | Resolved branch target |
| upd_tid_i | input | TID_W | Thread number of the update |
| hit_o | output | 1 | Registered hit flag |
| tgt_o | output | PC_W | Registered predicted target, zero on a miss |

## Verification
A corrupted valid flag, tag or thread number shows up at the ports on the very next lookup of that slot. It appears as a false hit, a missing hit, or a nonzero target paired with a miss. Each of these is visible one cycle after the lookup is presented. A wrong index or tag slice shows up later, as two addresses that alias when they should not, or as a slot that evicts the wrong partner. For that reason the bench mixes random traffic with addresses chosen to collide on index but differ in tag. A read-during-write ordering fault shows up only in the same-slot, same-cycle case, so that case is driven on purpose.

// File: rtl/tbtb_pkg.sv
package tbtb_pkg;
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/tbtb_addr_split.sv
module tbtb_addr_split #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned SHIFT = 2,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 8
) (
   input  logic [PC_W-1:0]  pc_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [TAG_W-1:0] tag_o
);
   logic [PC_W-1:0] sh_idx, sh_tag;
   always_comb begin
      sh_idx = pc_i >> SHIFT;
      sh_tag = pc_i >> (SHIFT + IDX_W);
      idx_o  = sh_idx[IDX_W-1:0];
      tag_o  = sh_tag[TAG_W-1:0];
   end
endmodule

// File: rtl/tbtb_store.sv
module tbtb_store #(
   parameter int unsigned SLOTS = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned TAG_W = 8,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned TID_W = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic [PC_W-1:0]  wr_tgt_i,
   input  logic [TID_W-1:0] wr_tid_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_vld_o,
   output logic [TAG_W-1:0] rd_tag_o,
   output logic [PC_W-1:0]  rd_tgt_o,
   output logic [TID_W-1:0] rd_tid_o
);
   logic [SLOTS-1:0] vld_q;
   logic [TAG_W-1:0] tag_q [SLOTS];
   logic [PC_W-1:0]  tgt_q [SLOTS];
   logic [TID_W-1:0] tid_q [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk_i) begin
         if (!rst_ni || flush_i) begin
            vld_q[s] <= 1'b0;
         end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
            vld_q[s] <= 1'b1;
         end
      end
      always_ff @(posedge clk_i) begin
         if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
            tag_q[s] <= wr_tag_i;
            tgt_q[s] <= wr_tgt_i;
            tid_q[s] <= wr_tid_i;
         end
      end
   end

   always_comb begin
      rd_vld_o = vld_q[rd_idx_i];
      rd_tag_o = tag_q[rd_idx_i];
      rd_tgt_o = tgt_q[rd_idx_i];
      rd_tid_o = tid_q[rd_idx_i];
   end
endmodule

// File: rtl/tbtb_top.sv
module tbtb_top #(
   parameter int unsigned SLOTS = 16,
   parameter int unsigned TAG_W = 8,
   parameter int unsigned SHIFT = 2,
   parameter int unsigned PC_W  = 32,
   parameter int unsigned TID_W = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             look_vld_i,
   input  logic [PC_W-1:0]  look_pc_i,
   input  logic [TID_W-1:0] look_tid_i,
   input  logic             upd_vld_i,
   input  logic [PC_W-1:0]  upd_pc_i,
   input  logic [PC_W-1:0]  upd_tgt_i,
   input  logic [TID_W-1:0] upd_tid_i,
   output logic             hit_o,
   output logic [PC_W-1:0]  tgt_o
);
   import tbtb_pkg::*;
   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (!is_pow2(SLOTS)) begin : g_bad_slots
      $error("tbtb_top: SLOTS (R8) must be a power of two");
   end
   if (SHIFT + IDX_W + TAG_W > PC_W) begin : g_bad_widths
      $error("tbtb_top: tag and index exceed PC width");
   end

   logic [IDX_W-1:0] l_idx, u_idx;
   logic [TAG_W-1:0] l_tag, u_tag;
   logic             s_vld;
   logic [TAG_W-1:0] s_tag;
   logic [PC_W-1:0]  s_tgt;
   logic [TID_W-1:0] s_tid;
   logic             match;

   tbtb_addr_split #(.PC_W(PC_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W))
      look_split_i (.pc_i(look_pc_i), .idx_o(l_idx), .tag_o(l_tag));
   tbtb_addr_split #(.PC_W(PC_W), .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W))
      upd_split_i (.pc_i(upd_pc_i), .idx_o(u_idx), .tag_o(u_tag));

   tbtb_store #(.SLOTS(SLOTS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .TID_W(TID_W))
      store_i (
         .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
         .wr_en_i(upd_vld_i), .wr_idx_i(u_idx), .wr_tag_i(u_tag),
         .wr_tgt_i(upd_tgt_i), .wr_tid_i(upd_tid_i),
         .rd_idx_i(l_idx), .rd_vld_o(s_vld), .rd_tag_o(s_tag),
         .rd_tgt_o(s_tgt), .rd_tid_o(s_tid));

   assign match = look_vld_i && s_vld && (s_tag == l_tag) && (s_tid == look_tid_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hit_o <= 1'b0;
         tgt_o <= '0;
      end else begin
         hit_o <= match;
         tgt_o <= match ? s_tgt : '0;
      end
   end
endmodule

// File: rtl/tbtb_chk.sv
module tbtb_chk #(
   parameter int unsigned PC_W = 32
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            flush_i,
   input logic            look_vld_i,
   input logic            hit_o,
   input logic [PC_W-1:0] tgt_o
);
   logic past_ok;
   always_ff @(posedge clk_i) past_ok <= rst_ni;

   assert_miss_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_o |-> tgt_o == '0);
   assert_idle_no_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && !look_vld_i |=> !hit_o);
   assert_flush_empties_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && flush_i |=> ##1 !hit_o);
   assert_reset_quiet_R1: assert property (@(posedge clk_i)
      !rst_ni |=> !hit_o && tgt_o == '0);
endmodule

bind tbtb_top tbtb_chk #(.PC_W(PC_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .look_vld_i(look_vld_i),
   .hit_o(hit_o), .tgt_o(tgt_o));

// File: tb/tbtb_top_tb_top.sv
module tbtb_top_tb_top;
   localparam int unsigned SLOTS = 16, TAG_W = 8, SHIFT = 2, PC_W = 32, TID_W = 1;
   localparam int unsigned IDX_W = 4;

   logic clk = 0, rst_n = 0, flush = 0, lv = 0, uv = 0;
   logic [PC_W-1:0] lpc = '0, upc = '0, utgt = '0;
   logic [TID_W-1:0] ltid = '0, utid = '0;
   logic hit;
   logic [PC_W-1:0] tgt;
   int checks = 0, fails = 0;

   bit              m_v  [SLOTS];
   logic [TAG_W-1:0] m_tag [SLOTS];
   logic [PC_W-1:0] m_tgt [SLOTS];
   logic [TID_W-1:0] m_tid [SLOTS];

   always #2 clk = ~clk;

   tbtb_top #(.SLOTS(SLOTS), .TAG_W(TAG_W), .SHIFT(SHIFT), .PC_W(PC_W), .TID_W(TID_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .look_vld_i(lv), .look_pc_i(lpc),
      .look_tid_i(ltid), .upd_vld_i(uv), .upd_pc_i(upc), .upd_tgt_i(utgt),
      .upd_tid_i(utid), .hit_o(hit), .tgt_o(tgt));

   function automatic int unsigned f_idx(logic [PC_W-1:0] pc);
      return (pc >> SHIFT) % SLOTS;
   endfunction
   function automatic logic [TAG_W-1:0] f_tag(logic [PC_W-1:0] pc);
      logic [PC_W-1:0] t = pc >> (SHIFT + IDX_W);
      return t[TAG_W-1:0];
   endfunction
   function automatic logic [PC_W-1:0] mk_pc(int unsigned idx, int unsigned tg);
      return PC_W'(((tg << IDX_W) | idx) << SHIFT);
   endfunction

   task automatic check(string req, logic eh, logic [PC_W-1:0] et);
      checks++;
      if (hit !== eh || tgt !== et) begin
         fails++;
         $display("FAIL %s: hit=%0b tgt=%h expected hit=%0b tgt=%h", req, hit, tgt, eh, et);
      end
   endtask

   // One cycle: drive, compute expectation from model (old contents), update model, check.
   task automatic cycle(string req, bit dl, logic [PC_W-1:0] pl, logic [TID_W-1:0] tl,
                        bit du, logic [PC_W-1:0] pu, logic [PC_W-1:0] tu,
                        logic [TID_W-1:0] tdu, bit fl);
      logic eh; logic [PC_W-1:0] et; int unsigned li, ui;
      lv = dl; lpc = pl; ltid = tl; uv = du; upc = pu; utgt = tu; utid = tdu; flush = fl;
      li = f_idx(pl); ui = f_idx(pu);
      eh = dl && m_v[li] && m_tag[li] == f_tag(pl) && m_tid[li] == tl;
      et = eh ? m_tgt[li] : '0;
      if (fl) begin
         for (int s = 0; s < SLOTS; s++) m_v[s] = 0;
      end else if (du) begin
         m_v[ui] = 1; m_tag[ui] = f_tag(pu); m_tgt[ui] = tu; m_tid[ui] = tdu;
      end
      @(posedge clk); #1;
      check(req, eh, et);
      lv = 0; uv = 0; flush = 0;
   endtask

   task automatic look(string req, logic [PC_W-1:0] p, logic [TID_W-1:0] t);
      cycle(req, 1, p, t, 0, '0, '0, '0, 0);
   endtask
   task automatic upd(logic [PC_W-1:0] p, logic [PC_W-1:0] g, logic [TID_W-1:0] t);
      cycle("R6", 0, '0, '0, 1, p, g, t, 0);
   endtask

   initial begin
      #40000;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int s = 0; s < SLOTS; s++) m_v[s] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      check("R1 reset", 0, '0);
      look("R1 empty after reset", mk_pc(3, 5), 0);
      // R6 write then R3/R5 hit
      upd(mk_pc(3, 5), 32'hDEAD_BEE0, 0);
      look("R3 hit", mk_pc(3, 5), 0);
      look("R3 wrong tid", mk_pc(3, 5), 1);
      look("R2 wrong tag", mk_pc(3, 6), 0);
      look("R2 other index", mk_pc(4, 5), 0);
      // R2 alignment bits ignored, bits above TAG_W ignored
      look("R2 low bits", mk_pc(3, 5) | 32'h3, 0);
      look("R2 high bits", mk_pc(3, 5) | (32'h1 << (SHIFT + IDX_W + TAG_W)), 0);
      // R5 lookup strobe low
      cycle("R5 idle", 0, mk_pc(3, 5), 0, 0, '0, '0, '0, 0);
      // R6 eviction by alias
      upd(mk_pc(3, 9), 32'h0000_1234, 1);
      look("R6 evicted", mk_pc(3, 5), 0);
      look("R6 new", mk_pc(3, 9), 1);
      // R7 read-before-write
      cycle("R7 old", 1, mk_pc(3, 9), 1, 1, mk_pc(3, 9), 32'h0000_5678, 1, 0);
      look("R7 new", mk_pc(3, 9), 1);
      // R1 flush, and flush beats update
      cycle("R1 flush", 0, '0, '0, 1, mk_pc(7, 1), 32'h0000_0700, 0, 1);
      look("R1 after flush", mk_pc(3, 9), 1);
      look("R1 update lost", mk_pc(7, 1), 0);
      // random traffic on a narrow address range to force aliasing
      for (int i = 0; i < 3000; i++) begin
         bit dl = $urandom_range(0, 3) != 0;
         bit du = $urandom_range(0, 1);
         bit fl = $urandom_range(0, 60) == 0;
         cycle("R3 random", dl, mk_pc($urandom_range(0, 15), $urandom_range(0, 3)) | 32'($urandom_range(0, 3)),
               TID_W'($urandom_range(0, 1)), du,
               mk_pc($urandom_range(0, 15), $urandom_range(0, 3)), $urandom,
               TID_W'($urandom_range(0, 1)), fl);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule